// File: doc/BRIEF.md
# DMA Transfer Count and Reload Unit

This block holds the transfer-count state of one DMA channel. Software programs a main count, which is mirrored into a shadow count as it is written. The shadow count can also be written on its own. The channel's bus engine pulses `xferDone` once for each finished transfer. The unit decrements its counters on each pulse and raises single-cycle strobes. These strobes mark the end of the transfer sequence, the half-way point of a run, and the moments when the address engine must reload its source and destination pointers.

There are three operating styles. Normal mode counts down once and then stops. Repeat mode refills the main count from the shadow each time the sequence ends. Reload mode turns the low byte of the shadow into an 8-bit sub-counter. When that sub-counter runs out, it asks for an address reload and refills itself from shadow bits 23:16. In normal and repeat mode, a half-way strobe can be enabled. It fires once per run, when the remaining main count equals half of the shadow count, rounded down.

All strobes are registered. Each appears in the clock cycle after the edge that sampled the transfer pulse that caused it.

Top module: `dma_count_reload`

## Requirements
- R1: A write through `wrMain` loads the main count and the shadow count with the same value, `wrData[23:0]`.
- R2: `rdMain[31:24]` and `rdShadow[31:24]` always read 0, whatever was written to `wrData[31:24]`.
- R3: With `mode` 00, each transfer pulse on a non-zero main count decrements it by one. `endStrobe` pulses for one cycle after the pulse that takes the count from 1 to 0.
- R4: A transfer pulse while the main count is 0 leaves both counts unchanged and raises no strobe. `mode` 11 behaves exactly like 00.
- R5: With `mode` 01, the pulse that takes the main count from 1 to 0 raises `endStrobe` and reloads the main count from the shadow count, starting a new run.
- R6: With `mode` 10, each pulse decrements shadow bits 7:0. On the pulse that brings them to 0, `addrReload` pulses for one cycle, bits 7:0 are refilled from bits 23:16, and bits 23:16 stay unchanged.
- R7: `halfStrobe` pulses for one cycle after the first pulse of a run that leaves the main count equal to floor(shadow/2). It does so only while `halfEn` is 1 and `mode` is not 10, and never twice in one run. A write or a repeat refill starts a new run.
- R8: During and right after reset, both counts are 0 and all strobes are low.
- R9: A write in the same cycle as a transfer pulse takes priority, and that pulse is not counted. `wrShadow` alone changes only the shadow count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrMain | input | 1 | Write main count and mirror it into the shadow |
| wrShadow | input | 1 | Write the shadow count only |
| wrData | input | 32 | Write data |
| mode | input | 2 | 00 normal, 01 repeat, 10 reload, 11 normal |
| halfEn | input | 1 | Enable the half-way strobe |
| xferDone | input | 1 | One-cycle pulse per completed transfer |
| rdMain | output | 32 | Current main count, zero-extended |
| rdShadow | output | 32 | Current shadow count, zero-extended |
| endStrobe | output | 1 | Sequence end strobe |
| halfStrobe | output | 1 | Half-way strobe |
| addrReload | output | 1 | Address reload request strobe |

## Verification
A wrong decrement or a missed refill appears on `rdMain` or `rdShadow` in the cycle after the offending transfer pulse. A misplaced end condition shows as an `endStrobe` that is missing or comes one pulse early or late. A stuck half-run flag is only exposed on a later run, because it suppresses the half-way strobe of a repeated sequence. For that reason, repeat mode is exercised across two full runs. A sub-counter refill fault shows on `addrReload` and on the low byte of `rdShadow` on the same cycle.

// File: rtl/dma_count_pkg.sv
package dma_count_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_ALT    = 2'b11
  } cntMode_e;

  typedef struct packed {
    logic loadMain;
    logic loadShadow;
    logic decMain;
    logic refillMain;
    logic decSub;
    logic refillSub;
  } cntCtrl_t;
endpackage

// File: rtl/dma_count_datapath.sv
module dma_count_datapath
  import dma_count_pkg::*;
#(
  parameter int COUNT_W    = 24,
  parameter int SUB_W      = 8,
  parameter int RELOAD_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntCtrl_t           ctrl,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] mainCnt,
  output logic [COUNT_W-1:0] shadowCnt
);
  localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= '0;
    end else if (ctrl.loadMain) begin
      mainCnt <= wrData;
    end else if (ctrl.refillMain) begin
      mainCnt <= shadowCnt;
    end else if (ctrl.decMain) begin
      mainCnt <= mainCnt - COUNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCnt <= '0;
    end else if (ctrl.loadShadow) begin
      shadowCnt <= wrData;
    end else if (ctrl.refillSub) begin
      shadowCnt[SUB_W-1:0] <= shadowCnt[RELOAD_LSB +: SUB_W];
    end else if (ctrl.decSub) begin
      shadowCnt[SUB_W-1:0] <= shadowCnt[SUB_W-1:0] - SUB_ONE;
    end
  end
endmodule

// File: rtl/dma_count_control.sv
module dma_count_control
  import dma_count_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int SUB_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrMain,
  input  logic               wrShadow,
  input  logic [1:0]         mode,
  input  logic               halfEn,
  input  logic               xferDone,
  input  logic [COUNT_W-1:0] mainCnt,
  input  logic [COUNT_W-1:0] shadowCnt,
  output cntCtrl_t           ctrl,
  output logic               endStrobe,
  output logic               halfStrobe,
  output logic               addrReload
);
  logic active;
  logic isLast;
  logic isRepeat;
  logic isReload;
  logic halfHit;
  logic halfDone;
  logic [COUNT_W-1:0] nextMain;
  logic [COUNT_W-1:0] halfMark;

  always_comb begin
    isRepeat = (mode == MODE_REPEAT);
    isReload = (mode == MODE_RELOAD);
    active   = xferDone && !wrMain && !wrShadow && (mainCnt != '0);
    isLast   = (mainCnt == COUNT_W'(1));
    nextMain = mainCnt - COUNT_W'(1);
    halfMark = shadowCnt >> 1;
    halfHit  = active && halfEn && !isReload && !halfDone && (nextMain == halfMark);

    ctrl.loadMain   = wrMain;
    ctrl.loadShadow = wrMain || wrShadow;
    ctrl.refillMain = active && isRepeat && isLast;
    ctrl.decMain    = active && !(isRepeat && isLast);
    ctrl.refillSub  = active && isReload && (shadowCnt[SUB_W-1:0] <= SUB_W'(1));
    ctrl.decSub     = active && isReload && (shadowCnt[SUB_W-1:0] > SUB_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfDone   <= 1'b0;
      endStrobe  <= 1'b0;
      halfStrobe <= 1'b0;
      addrReload <= 1'b0;
    end else begin
      if (wrMain || wrShadow || ctrl.refillMain) begin
        halfDone <= 1'b0;
      end else if (halfHit) begin
        halfDone <= 1'b1;
      end
      endStrobe  <= active && isLast;
      halfStrobe <= halfHit;
      addrReload <= ctrl.refillSub;
    end
  end
endmodule

// File: rtl/dma_count_reload.sv
module dma_count_reload
  import dma_count_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COUNT_W    = 24,
  parameter int SUB_W      = 8,
  parameter int RELOAD_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrMain,
  input  logic              wrShadow,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        mode,
  input  logic              halfEn,
  input  logic              xferDone,
  output logic [DATA_W-1:0] rdMain,
  output logic [DATA_W-1:0] rdShadow,
  output logic              endStrobe,
  output logic              halfStrobe,
  output logic              addrReload
);
  localparam int PAD_W = DATA_W - COUNT_W;

  cntCtrl_t           ctrl;
  logic [COUNT_W-1:0] mainCnt;
  logic [COUNT_W-1:0] shadowCnt;

  dma_count_control #(.COUNT_W(COUNT_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrMain(wrMain), .wrShadow(wrShadow),
    .mode(mode), .halfEn(halfEn), .xferDone(xferDone),
    .mainCnt(mainCnt), .shadowCnt(shadowCnt), .ctrl(ctrl),
    .endStrobe(endStrobe), .halfStrobe(halfStrobe), .addrReload(addrReload)
  );

  dma_count_datapath #(.COUNT_W(COUNT_W), .SUB_W(SUB_W), .RELOAD_LSB(RELOAD_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData[COUNT_W-1:0]),
    .mainCnt(mainCnt), .shadowCnt(shadowCnt)
  );

  assign rdMain   = {{PAD_W{1'b0}}, mainCnt};
  assign rdShadow = {{PAD_W{1'b0}}, shadowCnt};
endmodule

// File: rtl/dma_count_reload_chk.sv
module dma_count_reload_chk #(
  parameter int DATA_W     = 32,
  parameter int SUB_W      = 8,
  parameter int RELOAD_LSB = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrMain,
  input logic              wrShadow,
  input logic [1:0]        mode,
  input logic              halfEn,
  input logic              xferDone,
  input logic [DATA_W-1:0] rdMain,
  input logic [DATA_W-1:0] rdShadow,
  input logic              endStrobe,
  input logic              halfStrobe,
  input logic              addrReload
);
  // R1
  write_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrMain |=> rdMain == rdShadow);

  // R3
  end_from_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    endStrobe |-> $past(rdMain) == DATA_W'(1));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdMain == '0 && !wrMain) |=> rdMain == '0);

  // R5
  repeat_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && rdMain == DATA_W'(1) && xferDone && !wrMain && !wrShadow)
      |=> (rdMain == $past(rdShadow)) && endStrobe);

  // R6
  reload_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrReload |-> rdShadow[SUB_W-1:0] == rdShadow[RELOAD_LSB +: SUB_W]);

  // R7
  half_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfStrobe |-> ($past(halfEn) && $past(mode) != 2'b10));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!endStrobe && !halfStrobe && !addrReload && rdMain == '0));
endmodule

bind dma_count_reload dma_count_reload_chk #(
  .DATA_W(DATA_W), .SUB_W(SUB_W), .RELOAD_LSB(RELOAD_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .wrMain(wrMain), .wrShadow(wrShadow),
  .mode(mode), .halfEn(halfEn), .xferDone(xferDone),
  .rdMain(rdMain), .rdShadow(rdShadow), .endStrobe(endStrobe),
  .halfStrobe(halfStrobe), .addrReload(addrReload)
);

// File: tb/dma_count_reload_tb.sv
module dma_count_reload_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;
  // vector: kind[2] mode[2] halfEn[1] data[32] expMain[32] expShadow[32] flags{end,half,addr}[3] req[4]
  // kind: 1 write main, 2 write shadow, 3 transfer pulse
  localparam logic [107:0] VEC [NVEC] = '{
    // R1 R3 R7: normal run of 5 with half-way strobe
    {2'd1, 2'b00, 1'b1, 32'd5, 32'd5, 32'd5, 3'b000, 4'd1},
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd4, 32'd5, 3'b000, 4'd3},
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd3, 32'd5, 3'b000, 4'd3},
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd2, 32'd5, 3'b010, 4'd7},
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd1, 32'd5, 3'b000, 4'd7},
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd0, 32'd5, 3'b100, 4'd3},
    // R4: pulse at zero ignored
    {2'd3, 2'b00, 1'b1, 32'd0, 32'd0, 32'd5, 3'b000, 4'd4},
    // R5 R7: repeat across two runs
    {2'd1, 2'b01, 1'b1, 32'd3, 32'd3, 32'd3, 3'b000, 4'd1},
    {2'd3, 2'b01, 1'b1, 32'd0, 32'd2, 32'd3, 3'b000, 4'd5},
    {2'd3, 2'b01, 1'b1, 32'd0, 32'd1, 32'd3, 3'b010, 4'd7},
    {2'd3, 2'b01, 1'b1, 32'd0, 32'd3, 32'd3, 3'b100, 4'd5},
    {2'd3, 2'b01, 1'b1, 32'd0, 32'd2, 32'd3, 3'b000, 4'd5},
    {2'd3, 2'b01, 1'b1, 32'd0, 32'd1, 32'd3, 3'b010, 4'd7},
    // R6: reload sub-counter 3 with reload value 3
    {2'd1, 2'b10, 1'b0, 32'h0003_0003, 32'h0003_0003, 32'h0003_0003, 3'b000, 4'd1},
    {2'd3, 2'b10, 1'b0, 32'd0, 32'h0003_0002, 32'h0003_0002, 3'b000, 4'd6},
    {2'd3, 2'b10, 1'b0, 32'd0, 32'h0003_0001, 32'h0003_0001, 3'b000, 4'd6},
    {2'd3, 2'b10, 1'b0, 32'd0, 32'h0003_0000, 32'h0003_0003, 3'b001, 4'd6},
    // R7: half-way disabled
    {2'd1, 2'b00, 1'b0, 32'd4, 32'd4, 32'd4, 3'b000, 4'd1},
    {2'd3, 2'b00, 1'b0, 32'd0, 32'd3, 32'd4, 3'b000, 4'd7},
    {2'd3, 2'b00, 1'b0, 32'd0, 32'd2, 32'd4, 3'b000, 4'd7},
    // R4: mode 11 acts as normal
    {2'd1, 2'b11, 1'b0, 32'd1, 32'd1, 32'd1, 3'b000, 4'd1},
    {2'd3, 2'b11, 1'b0, 32'd0, 32'd0, 32'd1, 3'b100, 4'd4},
    {2'd3, 2'b11, 1'b0, 32'd0, 32'd0, 32'd1, 3'b000, 4'd4},
    // R9: shadow-only write
    {2'd2, 2'b00, 1'b0, 32'd9, 32'd0, 32'd9, 3'b000, 4'd9},
    // R2: upper byte discarded
    {2'd1, 2'b00, 1'b0, 32'hABCD_EF12, 32'h00CD_EF12, 32'h00CD_EF12, 3'b000, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrMain = 1'b0;
  logic        wrShadow = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  mode = 2'b00;
  logic        halfEn = 1'b0;
  logic        xferDone = 1'b0;
  logic [31:0] rdMain;
  logic [31:0] rdShadow;
  logic        endStrobe;
  logic        halfStrobe;
  logic        addrReload;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_count_reload u_dut (
    .clk(clk), .rstN(rstN), .wrMain(wrMain), .wrShadow(wrShadow),
    .wrData(wrData), .mode(mode), .halfEn(halfEn), .xferDone(xferDone),
    .rdMain(rdMain), .rdShadow(rdShadow), .endStrobe(endStrobe),
    .halfStrobe(halfStrobe), .addrReload(addrReload)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic [31:0] eMain, input logic [31:0] eShadow, input logic [2:0] eFlags);
    check(req, "main", rdMain, eMain);
    check(req, "shadow", rdShadow, eShadow);
    check(req, "strobes", {29'd0, endStrobe, halfStrobe, addrReload}, {29'd0, eFlags});
  endtask

  task automatic drive(input logic wm, input logic ws, input logic xd, input logic [31:0] d,
                       input logic [1:0] m, input logic he);
    @(negedge clk);
    wrMain = wm; wrShadow = ws; xferDone = xd; wrData = d; mode = m; halfEn = he;
    @(negedge clk);
    wrMain = 1'b0; wrShadow = 1'b0; xferDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    checkAll(8, 32'd0, 32'd0, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    checkAll(8, 32'd0, 32'd0, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      logic [107:0] v;
      v = VEC[i];
      drive(v[107:106] == 2'd1, v[107:106] == 2'd2, v[107:106] == 2'd3,
            v[102:71], v[105:104], v[103]);
      checkAll(int'(v[3:0]), v[70:39], v[38:7], v[6:4]);
    end

    // R9: write and pulse in the same cycle, write wins
    drive(1'b1, 1'b0, 1'b1, 32'd7, 2'b00, 1'b0);
    checkAll(9, 32'd7, 32'd7, 3'b000);
    drive(1'b0, 1'b1, 1'b1, 32'h20, 2'b00, 1'b0);
    checkAll(9, 32'd7, 32'h20, 3'b000);
    // R3: strobes last one cycle
    drive(1'b1, 1'b0, 1'b0, 32'd1, 2'b00, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 32'd0, 2'b00, 1'b0);
    checkAll(3, 32'd0, 32'd1, 3'b100);
    @(negedge clk);
    checkAll(3, 32'd0, 32'd1, 3'b000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule